// File: doc/BRIEF.md
# Leading-One Predictor for Significand Subtraction

This block estimates where the leading one of the difference A − B will land while a separate subtractor is still forming that difference. The subtraction is understood as A plus the one's complement of B plus a forced carry into the least significant position. From the operand bits alone, the block builds a per-bit indicator vector in parallel. A tree encoder counts the leading zeros of that vector in the same cycle, and the count is the left shift that a post-normalization barrel shifter applies.

The estimate is either exact or one position too small. The true leading one sits at the predicted position or one bit to its right. When the true difference arrives, the block looks at the single bit of it at the predicted position and raises a correction flag if that bit is 0. The flag tells the downstream logic that one more left shift by one position is needed.

When the operands are equal, a zero-result flag is raised and the shift count saturates to N. The operands must be magnitude-ordered with A ≥ B. For A < B the outputs are unspecified. All outputs are registered and appear one clock after the inputs.

Top module: `lead_one_predict`

## Requirements
- R1: Indicator bit i (for i ≥ 1) is 1 exactly when a[i] differs from b[i] and at least one of a[i-1] and the inverse of b[i-1] is 1. Bit 0 is 1 exactly when a[0] differs from b[0], because the forced carry-in of 1 stands in for the bit below it.
- R2: For A > B, norm_shift equals the number of zero indicator bits above the highest set indicator bit, counted down from bit N-1. For example, with N = 8, a = 0x50 and b = 0x30 give 2, and a = 0x04 and b = 0x03 give 7.
- R3: For A > B, the leading one of A − B lies at bit N-1-norm_shift or at bit N-2-norm_shift, and no bit of A − B above bit N-1-norm_shift is set.
- R4: For A > B, fix_one is 1 exactly when bit N-1-norm_shift of diff is 0.
- R5: When A equals B, res_zero is 1, norm_shift is N and fix_one is 0. For A > B, res_zero is 0 and norm_shift is less than N.
- R6: Each output reflects the inputs present at the previous rising clock edge. While rst_n is low, all outputs are 0.
- R7: fix_one depends on no bit of diff other than bit N-1-norm_shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a | input | N | Minuend significand (A ≥ B) |
| b | input | N | Subtrahend significand |
| diff | input | N | True difference A − B from the external subtractor |
| norm_shift | output | $clog2(N+1) | Predicted left shift for normalization |
| res_zero | output | 1 | Operands equal, difference is zero |
| fix_one | output | 1 | One extra left shift by one position is needed |

## Verification
The operand pairs are chosen to separate the two outcomes of the prediction. Some pairs have a lone borrow chain that cancels down to a difference of 1, where the indicator must reach bit 0 through the forced carry-in. Other pairs, such as 0x80 − 0x01 and 0x20 − 0x11, place the indicator one bit above the true leading one and so must raise the correction flag, while pairs with a set bit just below the first differing bit must not raise it. Equal operands check the zero flag and the saturated count. Substituted diff values with altered bits outside the predicted position show that only the selected bit steers the flag. A random sweep of ordered pairs compares the count with a serial scan of the indicator and checks the one-position window against the true difference.

// File: rtl/lead_one_predict.sv
module lead_one_predict #(
  parameter int N = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             a,
  input  logic [N-1:0]             b,
  input  logic [N-1:0]             diff,
  output logic [$clog2(N+1)-1:0]   norm_shift,
  output logic                     res_zero,
  output logic                     fix_one
);
  localparam int L  = $clog2(N);
  localparam int P  = 1 << L;
  localparam int CW = $clog2(N+1);

  // R1: indicator vector, carry-in acts as the bit below position 0
  logic [N-1:0] ind;
  assign ind = (a ^ b) & ({a[N-2:0], 1'b1} | ~{b[N-2:0], 1'b0});

  logic [P-1:0] ind_pad;
  assign ind_pad = P'(ind) << (P - N);

  for (genvar l = 0; l <= L; l++) begin : g_lvl
    localparam int W = P >> l;
    logic         vld [W];
    logic [L-1:0] cnt [W];
    for (genvar j = 0; j < W; j++) begin : g_node
      if (l == 0) begin : g_leaf
        assign vld[j] = ind_pad[P-1-j];
        assign cnt[j] = '0;
      end else begin : g_join
        assign vld[j] = g_lvl[l-1].vld[2*j] | g_lvl[l-1].vld[2*j+1];
        assign cnt[j] = g_lvl[l-1].vld[2*j] ? g_lvl[l-1].cnt[2*j]
                                            : (g_lvl[l-1].cnt[2*j+1] | L'(1 << (l-1)));
      end
    end
  end

  logic         any_one;
  logic [L-1:0] lz;
  logic [L-1:0] pos;
  logic         same;
  assign any_one = g_lvl[L].vld[0];
  assign lz      = g_lvl[L].cnt[0];
  assign pos     = L'(N-1) - lz;
  assign same    = (a == b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_shift <= '0;
      res_zero   <= 1'b0;
      fix_one    <= 1'b0;
    end else begin
      norm_shift <= (same || !any_one) ? CW'(N) : CW'(lz);
      res_zero   <= same;
      fix_one    <= any_one && !same && !diff[pos];
    end
  end

  logic [N-1:0] dsh;
  assign dsh = diff << lz;

  AST_LEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (a > b) && (diff == a - b) |-> (dsh[N-1] | dsh[N-2]) && ((diff >> (N - int'(lz))) == '0)); // R3
  AST_ZERO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    res_zero |-> (norm_shift == CW'(N)) && !fix_one); // R5
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (a == b) |=> res_zero); // R5
  AST_NONZERO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (a > b) |=> !res_zero && (norm_shift < CW'(N))); // R5
endmodule

// File: tb/tb_lead_one_predict.sv
`timescale 1ns/1ps
module tb_lead_one_predict;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] a = '0, b = '0, diff = '0;
  logic [3:0] norm_shift;
  logic res_zero, fix_one;
  int errors = 0;
  int checks = 0;

  lead_one_predict #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .diff(diff),
    .norm_shift(norm_shift), .res_zero(res_zero), .fix_one(fix_one)
  );

  always #5 clk = ~clk;

  // {a, b, expected shift, expected fix}
  localparam logic [20:0] TV [12] = '{
    {8'h80, 8'h01, 4'd0, 1'b1},
    {8'h04, 8'h03, 4'd7, 1'b0},
    {8'hFF, 8'h00, 4'd0, 1'b0},
    {8'hC0, 8'h40, 4'd0, 1'b0},
    {8'h90, 8'h8F, 4'd7, 1'b0},
    {8'h50, 8'h30, 4'd2, 1'b0},
    {8'h20, 8'h11, 4'd3, 1'b1},
    {8'h01, 8'h00, 4'd7, 1'b0},
    {8'h02, 8'h01, 4'd7, 1'b0},
    {8'h03, 8'h01, 4'd6, 1'b0},
    {8'h10, 8'h0F, 4'd7, 1'b0},
    {8'h18, 8'h09, 4'd3, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_lz(logic [N-1:0] x, logic [N-1:0] y);
    for (int i = N-1; i >= 0; i--) begin
      logic lo;
      lo = (i == 0) ? 1'b1 : (x[i-1] | ~y[i-1]);
      if ((x[i] ^ y[i]) && lo) return N-1-i;
    end
    return N;
  endfunction

  function automatic int lead_pos(logic [N-1:0] d);
    for (int i = N-1; i >= 0; i--) if (d[i]) return i;
    return -1;
  endfunction

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic [N-1:0] d);
    @(negedge clk);
    a = x; b = y; diff = d;
    @(negedge clk);
  endtask

  task automatic window_chk(input logic [N-1:0] x, input logic [N-1:0] y);
    int p;
    int s;
    p = lead_pos(x - y);
    s = int'(norm_shift);
    chk("R3 window", int'((p == N-1-s) || (p == N-2-s)), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = 8'h80; b = 8'h01; diff = 8'h7F;
    repeat (3) @(negedge clk);
    chk("R6 reset shift", int'(norm_shift), 0);
    chk("R6 reset zero", int'(res_zero), 0);
    chk("R6 reset fix", int'(fix_one), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 12; k++) begin
      logic [7:0] x, y;
      x = TV[k][20:13]; y = TV[k][12:5];
      apply(x, y, x - y);
      chk("R2 shift", int'(norm_shift), int'(TV[k][4:1]));
      chk("R4 fix", int'(fix_one), int'(TV[k][0]));
      chk("R5 nonzero", int'(res_zero), 0);
      window_chk(x, y);
    end

    // R6: output holds until the next rising edge
    apply(8'h04, 8'h03, 8'h01);
    a = 8'hFF; b = 8'h00; diff = 8'hFF;
    #1 chk("R6 hold before edge", int'(norm_shift), 7);
    @(negedge clk);
    chk("R6 update after edge", int'(norm_shift), 0);

    apply(8'hA5, 8'hA5, 8'h00);
    chk("R5 equal shift", int'(norm_shift), N);
    chk("R5 equal zero", int'(res_zero), 1);
    chk("R5 equal fix", int'(fix_one), 0);
    apply(8'h00, 8'h00, 8'h3C);
    chk("R5 equal zero operands", int'(res_zero), 1);
    chk("R5 equal zero fix", int'(fix_one), 0);

    // R7: only bit N-1-shift of diff steers the flag
    apply(8'h80, 8'h01, 8'h00); chk("R7 bit7 clear", int'(fix_one), 1);
    apply(8'h80, 8'h01, 8'h55); chk("R7 bit7 clear", int'(fix_one), 1);
    apply(8'h80, 8'h01, 8'h80); chk("R7 bit7 set", int'(fix_one), 0);
    apply(8'h20, 8'h11, 8'h10); chk("R7 bit4 set", int'(fix_one), 0);
    apply(8'h20, 8'h11, 8'hEF); chk("R7 bit4 clear", int'(fix_one), 1);

    for (int k = 0; k < 300; k++) begin
      logic [7:0] x, y, t;
      x = 8'($urandom); y = 8'($urandom);
      if (x < y) begin t = x; x = y; y = t; end
      if (x == y) x = x + 8'd1;
      if (x == 8'd0) begin x = 8'd1; y = 8'd0; end
      apply(x, y, x - y);
      chk("R1 R2 random shift", int'(norm_shift), ref_lz(x, y));
      window_chk(x, y);
      chk("R4 random fix", int'(fix_one), int'(!((x - y) >> (N-1-int'(norm_shift)) & 8'd1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule